// File: doc/BRIEF.md
# Port-Expander Write Sequencer

This block is a write-only two-wire bus master that brings up a 16-bit port-expander slave and then keeps its output port loaded. After a single start trigger it plays out five fixed register writes that set up the expander. It then loops forever, writing the value 0x11 into the expander's port-data register. Each register write is a separate bus transaction.

The bus clock comes from the system clock through a reload counter. Every bit period is split into four equal phases. Both bus lines are open-drain. The block only ever pulls a line low or lets it go, and it reads the data line back to collect the slave's acknowledge. When a byte is refused, the block ends the transaction and raises its error flag. After one idle bit period it sends the same write again. While the set-up script is running the block reports busy. A single-cycle done pulse marks the moment the script has finished.

Top module: `expander_write_seq`

## Requirements
- R1: Each transaction is START, the address byte 0x40 (7-bit address 0x20 followed by a write bit of 0), a register byte, a data byte, then STOP. A fully acknowledged transaction carries exactly three bytes.
- R2: Bytes are sent most significant bit first. SDA changes only while SCL is low, except at START (SDA falls while SCL is high) and at STOP (SDA rises while SCL is high).
- R3: On the ninth clock of every byte the master releases SDA (sda_oe_o = 0) and samples the slave. It never drives an acknowledge itself.
- R4: An SCL bit period lasts 4*(DIV_RELOAD+1) system clocks. The reload is Fclk/(4*rate)-1, which gives 39 for a 16 MHz clock and a 100 kHz bus.
- R5: The set-up script writes, in this order: register 0x00 with 0x00, register 0x02 with 0x00, register 0x14 with 0xFF, register 0x0A with 0x00, register 0x04 with 0x00.
- R6: After the script, the block writes 0x11 to register 0x12 in an endless loop. Each write is its own START to STOP transaction.
- R7: When the slave refuses a byte (SDA high on the ninth clock), the block sets err_o, sends STOP directly after that byte, and later repeats the same write.
- R8: From the SDA rise of a STOP to the SDA fall of the next START, exactly 8*(DIV_RELOAD+1) clocks pass, which includes one full idle bit period.
- R9: busy_o is high from the trigger until the last script write completes with acknowledges. At that point done_o pulses high for exactly one cycle, in the same cycle busy_o falls. done_o never pulses again.
- R10: An output-enable of 1 pulls its line low, and a 1 on a line is made only by releasing it. In reset and while idle, both enables are 0. A start trigger that arrives once the block is running has no effect on the write order.
- R11: err_o stays high after a refusal until a later transaction completes fully acknowledged. err_o is 0 before any refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Trigger that begins the script, accepted only while idle |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High while the set-up script runs |
| done_o | output | 1 | One-cycle pulse when the script finishes |
| err_o | output | 1 | Set on a refused byte, cleared by the next fully acknowledged write |

## Verification
The assertions assume that the slave never holds SCL low and only changes SDA while SCL is low, and that sda_i follows the wired-AND of both drivers. The bench models the lines as that wired-AND and keeps SCL driven only by the master. Its slave pulls SDA only from an SCL fall to the next SCL fall, and only around the ninth clock. Refusals are placed at a random script write and byte from a fixed seed. A directed refusal is also placed on the data byte of a port write.

// File: rtl/exp_seq_pkg.sv
package exp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BYTE,
        ST_STOP,
        ST_GAP
    } seq_state_t;

    localparam int unsigned SCRIPT_LEN = 5;   // set-up writes before the loop
    localparam int unsigned IDX_W      = 3;

    typedef struct packed {
        seq_state_t         state;
        logic [1:0]         phase;   // quarter of the bit period
        logic [3:0]         bitn;    // 0..7 data, 8 acknowledge
        logic [1:0]         byten;   // 0 address, 1 register, 2 data
        logic [IDX_W-1:0]   idx;     // script position, SCRIPT_LEN = loop write
        logic               nack;
        logic               busy;
        logic               done;
        logic               err;
    } seq_regs_t;

endpackage

// File: rtl/quarter_tick.sv
module quarter_tick #(
    parameter int unsigned DIV_RELOAD = 39,
    localparam int unsigned CNT_W = (DIV_RELOAD < 1) ? 1 : $clog2(DIV_RELOAD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == CNT_W'(DIV_RELOAD));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/script_rom.sv
module script_rom
    import exp_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       reg_o,
    output logic [7:0]       dat_o
);
    always_comb begin
        unique case (idx_i)
            3'd0:    begin reg_o = 8'h00; dat_o = 8'h00; end
            3'd1:    begin reg_o = 8'h02; dat_o = 8'h00; end
            3'd2:    begin reg_o = 8'h14; dat_o = 8'hFF; end
            3'd3:    begin reg_o = 8'h0A; dat_o = 8'h00; end
            3'd4:    begin reg_o = 8'h04; dat_o = 8'h00; end
            default: begin reg_o = 8'h12; dat_o = 8'h11; end
        endcase
    end
endmodule

// File: rtl/line_decode.sv
module line_decode
    import exp_seq_pkg::*;
(
    input  seq_state_t state_i,
    input  logic [1:0] phase_i,
    input  logic [3:0] bitn_i,
    input  logic       bit_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o
);
    always_comb begin
        scl_oe_o = 1'b0;
        sda_oe_o = 1'b0;
        unique case (state_i)
            ST_START: begin
                scl_oe_o = (phase_i == 2'd3);
                sda_oe_o = phase_i[1];
            end
            ST_BYTE: begin
                scl_oe_o = (phase_i == 2'd0) || (phase_i == 2'd3);
                sda_oe_o = (bitn_i == 4'd8) ? 1'b0 : !bit_i;
            end
            ST_STOP: begin
                scl_oe_o = (phase_i == 2'd0);
                sda_oe_o = !phase_i[1];
            end
            default: begin
                scl_oe_o = 1'b0;
                sda_oe_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/expander_write_seq.sv
module expander_write_seq
    import exp_seq_pkg::*;
#(
    parameter int unsigned DIV_RELOAD = 39,
    parameter logic [6:0]  SLAVE_ADDR = 7'h20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(SCRIPT_LEN - 1);
    localparam logic [IDX_W-1:0] LOOP_IDX  = IDX_W'(SCRIPT_LEN);

    seq_regs_t  s_d, s_q;
    logic       tick;
    logic [7:0] reg_byte, dat_byte, cur_byte;
    logic       cur_bit;

    seq_state_t st_w;
    logic [1:0] ph_w;
    logic [3:0] bitn_w;

    assign st_w   = s_q.state;
    assign ph_w   = s_q.phase;
    assign bitn_w = s_q.bitn;

    quarter_tick #(.DIV_RELOAD(DIV_RELOAD)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (s_q.state != ST_IDLE),
        .tick_o (tick)
    );

    script_rom u_rom (
        .idx_i (s_q.idx),
        .reg_o (reg_byte),
        .dat_o (dat_byte)
    );

    always_comb begin
        unique case (s_q.byten)
            2'd0:    cur_byte = {SLAVE_ADDR, 1'b0};
            2'd1:    cur_byte = reg_byte;
            default: cur_byte = dat_byte;
        endcase
        cur_bit = cur_byte[3'd7 - s_q.bitn[2:0]];
    end

    line_decode u_lines (
        .state_i  (s_q.state),
        .phase_i  (s_q.phase),
        .bitn_i   (s_q.bitn),
        .bit_i    (cur_bit),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.state == ST_IDLE) begin
            if (start_i) begin
                s_d.state = ST_START;
                s_d.phase = 2'd0;
                s_d.idx   = '0;
                s_d.busy  = 1'b1;
                s_d.nack  = 1'b0;
            end
        end else if (tick) begin
            if (s_q.phase != 2'd3) begin
                s_d.phase = s_q.phase + 2'd1;
                // acknowledge sampled at the end of the high half of the ninth clock
                if (s_q.state == ST_BYTE && s_q.bitn == 4'd8 &&
                    s_q.phase == 2'd2 && sda_i) begin
                    s_d.nack = 1'b1;
                    s_d.err  = 1'b1;
                end
            end else begin
                s_d.phase = 2'd0;
                unique case (s_q.state)
                    ST_START: begin
                        s_d.state = ST_BYTE;
                        s_d.byten = 2'd0;
                        s_d.bitn  = 4'd0;
                    end
                    ST_BYTE: begin
                        if (s_q.bitn != 4'd8) begin
                            s_d.bitn = s_q.bitn + 4'd1;
                        end else if (s_q.nack || s_q.byten == 2'd2) begin
                            s_d.state = ST_STOP;
                        end else begin
                            s_d.byten = s_q.byten + 2'd1;
                            s_d.bitn  = 4'd0;
                        end
                    end
                    ST_STOP: begin
                        s_d.state = ST_GAP;
                        if (!s_q.nack) begin
                            s_d.err = 1'b0;
                            if (s_q.idx == LAST_INIT) begin
                                s_d.idx  = LOOP_IDX;
                                s_d.busy = 1'b0;
                                s_d.done = 1'b1;
                            end else if (s_q.idx != LOOP_IDX) begin
                                s_d.idx = s_q.idx + 1'b1;
                            end
                        end
                    end
                    default: begin
                        s_d.state = ST_START;
                        s_d.nack  = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{state: ST_IDLE, phase: 2'd0, bitn: 4'd0, byten: 2'd0,
                     idx: '0, nack: 1'b0, busy: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign err_o  = s_q.err;
endmodule

// File: rtl/exp_seq_checker.sv
module exp_seq_checker
    import exp_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sda_i,
    input logic       scl_oe_o,
    input logic       sda_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input seq_state_t st_w,
    input logic [1:0] ph_w,
    input logic [3:0] bitn_w,
    input logic       tick
);
    // R3: the master leaves SDA released for the whole acknowledge clock
    assert_no_master_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_BYTE && bitn_w == 4'd8) |-> !sda_oe_o);

    // R2: inside a byte, SDA holds while SCL is released
    assert_sda_steady_scl_high_R2: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_BYTE && $past(st_w) == ST_BYTE && !scl_oe_o && !$past(scl_oe_o))
        |-> $stable(sda_oe_o));

    // R9: done is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: done coincides with busy falling
    assert_done_with_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $fell(busy_o));

    // R7: a refused acknowledge raises the error flag
    assert_err_on_nack_R7: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_BYTE && bitn_w == 4'd8 && ph_w == 2'd2 && tick && sda_i) |=> err_o);

    // R10: both lines released while idle
    assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_IDLE) |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind expander_write_seq exp_seq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_i    (sda_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .st_w     (st_w),
    .ph_w     (ph_w),
    .bitn_w   (bitn_w),
    .tick     (tick)
);

// File: tb/tb_expander_write_seq.sv
module tb_expander_write_seq;
    localparam int DIV = 2;
    localparam int PH  = DIV + 1;
    localparam int LAST_TXN = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic slave_pull = 1'b0;
    logic scl_oe, sda_oe, busy, done, err;
    logic sda_line;

    assign sda_line = !(sda_oe || slave_pull);

    expander_write_seq #(.DIV_RELOAD(DIV)) dut (
        .clk (clk), .rst (rst), .start_i (start_i), .sda_i (sda_line),
        .scl_oe_o (scl_oe), .sda_oe_o (sda_oe),
        .busy_o (busy), .done_o (done), .err_o (err)
    );

    always #10 clk = !clk;   // 50 MHz

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_reg(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h02;
            2: return 8'h14;
            3: return 8'h0A;
            4: return 8'h04;
            default: return 8'h12;
        endcase
    endfunction

    function automatic int exp_dat(input int i);
        if (i == 2) return 8'hFF;
        if (i >= 5) return 8'h11;
        return 8'h00;
    endfunction

    // bench-side slave and monitor state
    int  cyc = 0, tc = 0, ei = 0, done_cnt = 0;
    int  bitcnt = 0, bytecnt = 0, last_rise = 0, last_stop = 0, inj_byte = 0;
    int  n1t, n1b, n2t = 9, n2b = 2;
    bit  have_rise = 0, nacked = 0, last_ok = 1, pscl = 1, psda = 1, seen_start = 0;
    logic [7:0] sh;
    logic [7:0] b [3];

    always @(negedge clk) begin
        bit scl, sda, inj;
        cyc++;
        scl = !scl_oe;
        sda = sda_line;
        if (!rst) begin
            if (done) done_cnt++;
            if (scl && pscl && psda && !sda) begin
                // START
                if (seen_start) chk(cyc - last_stop == 8 * PH, "R8 gap", cyc - last_stop, 8 * PH);
                chk(err == !last_ok, "R11 err at start", err, !last_ok);
                if (ei < 5) begin
                    chk(busy == 1'b1 && done_cnt == 0, "R9 busy during script", busy, 1);
                end else begin
                    chk(busy == 1'b0 && done_cnt == 1, "R9 done once", done_cnt, 1);
                end
                seen_start = 1; bitcnt = 0; bytecnt = 0; nacked = 0; have_rise = 0;
            end else if (scl && pscl && !psda && sda) begin
                // STOP
                last_stop = cyc;
                chk(b[0] == 8'h40, "R1 address byte", b[0], 8'h40);
                if (nacked) begin
                    chk(err == 1'b1, "R7 err set", err, 1);
                    chk(bytecnt == inj_byte + 1, "R7 stop after refused byte", bytecnt, inj_byte + 1);
                    if (bytecnt >= 2) chk(b[1] == exp_reg(ei), "R7 refused write register", b[1], exp_reg(ei));
                    last_ok = 0;
                end else begin
                    chk(bytecnt == 3, "R1 byte count", bytecnt, 3);
                    chk(b[1] == exp_reg(ei), ei < 5 ? "R5 register" : "R6 register", b[1], exp_reg(ei));
                    chk(b[2] == exp_dat(ei), ei < 5 ? "R5 data" : "R6 data", b[2], exp_dat(ei));
                    if (ei < 5) ei++;
                    last_ok = 1;
                end
                tc++;
            end else if (scl && !pscl) begin
                // SCL rise
                if (have_rise) chk(cyc - last_rise == 4 * PH, "R4 bit period", cyc - last_rise, 4 * PH);
                last_rise = cyc; have_rise = 1;
                if (bitcnt == 8) begin
                    chk(sda_oe == 1'b0, "R3 ack released", sda_oe, 0);
                    if (sda) nacked = 1;
                    if (bytecnt < 3) b[bytecnt] = sh;
                    bytecnt++;
                    bitcnt = 0;
                end else begin
                    sh = {sh[6:0], sda};
                    bitcnt++;
                end
            end else if (!scl && pscl) begin
                // SCL fall: slave acknowledge window
                inj = (tc == n1t && bytecnt == n1b) || (tc == n2t && bytecnt == n2b);
                if (bitcnt == 8 && inj) inj_byte = bytecnt;
                slave_pull = (bitcnt == 8) && !inj;
            end
        end
        pscl = scl;
        psda = sda_line;
    end

    initial begin
        void'($urandom(32'd1234));
        n1t = 1 + int'($urandom % 4);
        n1b = int'($urandom % 3);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R10 released in idle", {scl_oe, sda_oe}, 0);
        chk(!busy && !done && !err, "R9 reset status", {busy, done, err}, 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // directed: a second trigger while running must not restart the script
        while (tc < 2 && cyc < 150000) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (tc < LAST_TXN && cyc < 150000) @(negedge clk);
        if (tc < LAST_TXN) chk(1'b0, "R6 watchdog", tc, LAST_TXN);
        chk(done_cnt == 1, "R9 done count", done_cnt, 1);
        chk(ei == 5, "R5 script completed", ei, 5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule